// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block takes received Ethernet frames as a byte stream and writes them into system memory. Frame data goes into buffers of fixed size, and software owns these buffers. A ring of descriptors in memory points to the buffers. Each descriptor is two 32-bit words:

- **Address word.** It carries the buffer address in bits 31:2, an ownership flag in bit 0 and an end-of-ring marker in bit 1.
- **Status word.** It sits 4 bytes above the address word and describes what the engine placed in the buffer.

A frame longer than one buffer continues in the next descriptors in ring order. It wraps through the ring base when needed. Each descriptor is handed back to software by setting its ownership flag. The status word is written before the ownership flag, so software never sees a stale status.

Software loads the ring base through a one-cycle write strobe and then raises the enable input. After that, software polls descriptors, copies the frames out, and clears the ownership flags to return buffers to the engine. The engine stalls the stream (`s_ready` low) while it fetches a descriptor or writes one back. If the engine meets a descriptor that software still owns, it discards the rest of that frame and raises a sticky overrun flag. The address-filter results arrive as inputs together with the last byte of the frame.

The memory port does one access per cycle and is always ready. Read data returns on the cycle after the request.

Top module: `rxr_dma_writer`

## Requirements
- R1: A descriptor is the address word at the ring pointer and the status word at pointer+4. Descriptor reads use 8-byte-aligned addresses, and the ring base must be 8-byte aligned.
- R2: The engine only fills a descriptor whose address-word bit 0 is clear. When it is done with the buffer, it writes the status word first. In the next cycle it rewrites the address word with bit 0 set, keeping the address and bit 1 unchanged.
- R3: After a descriptor whose address-word bit 1 is set, the next descriptor is the ring base. Otherwise the pointer steps by 8 bytes.
- R4: Each buffer holds 128 bytes, starting at the address word with bits 1:0 cleared. Frame byte j goes to buffer byte j mod 128 of the frame's (j div 128)-th descriptor. Byte lane = address bits 1:0, little-endian within each 32-bit word.
- R5: Status bit 14 is set only in the descriptor holding the frame's first byte. Status bit 15 is set only in the descriptor holding the last byte of a frame that ended without error.
- R6: In the bit-15 descriptor, bits 11:0 hold the total frame length in bytes. Bit 31 holds the broadcast input, bits 26:23 hold the four address-match inputs (match 0 at bit 23), and bit 22 holds the type-match input. In every other descriptor these fields are zero.
- R7: If the current descriptor is still owned by software, the remainder of the frame is accepted and discarded. The sticky overrun flag is set. The owned descriptor is left untouched, and the next frame retries the same descriptor.
- R8: A frame whose last byte carries the error marker hands back every descriptor it used, without bit 15. The next frame starts at the descriptor after them.
- R9: A base write clears the overrun flag and restarts the ring at the new base.
- R10: While reception is disabled, no byte is accepted and no memory access is made. After re-enabling, the ring starts again at the base.
- R11: After reset, `s_ready`, `mem_req` and `ovr_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Reception enable |
| base_wr | input | 1 | Ring base load strobe |
| base_data | input | ADDR_W | Ring base address |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| s_err | input | 1 | Frame bad, qualified with s_eof |
| s_bcast | input | 1 | Broadcast destination, qualified with s_eof |
| s_amatch | input | 4 | Specific-address filter hits, qualified with s_eof |
| s_tmatch | input | 1 | Type-ID match, qualified with s_eof |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| ovr_flag | output | 1 | Sticky overrun, cleared by base_wr |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 128-byte buffers. It places a ring of only four descriptors in a 2 KB memory model, so the end-of-ring marker is passed repeatedly. Frames of 129, 256 and 300 bytes are long enough to cross buffers, and some of them straddle the wrap. Lengths that are exact buffer multiples, and a 1-of-4 partial final word, exercise the byte-enable and end-of-buffer corners. Ownership is flipped by hand to produce overrun both before the first byte and in the middle of a frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_RECV,
    ST_WDATA,
    ST_STAT,
    ST_OWN,
    ST_DROP
  } rxr_state_e;

  localparam int DESC_STEP = 8;
  localparam int LEN_W     = 12;
  localparam int SOF_POS   = 14;
  localparam int EOF_POS   = 15;
  localparam int TYPE_POS  = 22;
  localparam int AMATCH_LO = 23;
  localparam int BCAST_POS = 31;

  // Status word for one descriptor; length and match fields only on the closing one.
  function automatic logic [31:0] rxr_status_word(
    input logic             first,
    input logic             closing,
    input logic [LEN_W-1:0] len,
    input logic             bcast,
    input logic [3:0]       amatch,
    input logic             tmatch
  );
    logic [31:0] w;
    w = '0;
    w[SOF_POS] = first;
    if (closing) begin
      w[EOF_POS]          = 1'b1;
      w[LEN_W-1:0]        = len;
      w[BCAST_POS]        = bcast;
      w[AMATCH_LO +: 4]   = amatch;
      w[TYPE_POS]         = tmatch;
    end
    return w;
  endfunction

  // Buffer address carried by an address word.
  function automatic logic [31:0] rxr_buf_addr(input logic [31:0] w0);
    return {w0[31:2], 2'b00};
  endfunction

  // Address word handed back to software: ownership set, marker kept.
  function automatic logic [31:0] rxr_owned_word(input logic [31:0] buf_addr,
                                                 input logic       ring_end);
    return {buf_addr[31:2], ring_end, 1'b1};
  endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              restart,
  input  logic              advance,
  input  logic              ring_end,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (base_load) begin
      base_q <= base_val;
      ptr_q  <= base_val;
    end else if (restart) begin
      ptr_q <= base_q;
    end else if (advance) begin
      ptr_q <= ring_end ? base_q : ptr_q + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  byte_in,
  input  logic        flush,
  output logic [31:0] word_q,
  output logic [3:0]  be_q,
  output logic [1:0]  lane_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
    end else if (flush) begin
      be_q   <= '0;
      lane_q <= '0;
    end else if (take) begin
      word_q[lane_q*8 +: 8] <= byte_in;
      be_q[lane_q]          <= 1'b1;
      lane_q                <= lane_q + 2'd1;
    end
  end
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic              s_err,
  input  logic              s_bcast,
  input  logic [3:0]        s_amatch,
  input  logic              s_tmatch,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic              ovr_flag
);
  localparam int OFF_W = $clog2(BUF_BYTES) + 1;

  rxr_state_e        state_q;
  logic [ADDR_W-1:0] buf_q;
  logic              ring_end_q, first_q, done_q, good_q;
  logic [LEN_W-1:0]  len_q;
  logic [OFF_W-1:0]  off_q;
  logic              bc_q, tm_q, ovr_q;
  logic [3:0]        am_q;
  logic [ADDR_W-1:0] ptr;
  logic [31:0]       pk_word;
  logic [3:0]        pk_be;
  logic [1:0]        pk_lane;

  // Named internal events, used by the bound checker.
  logic restart, take, ev_fetch, ev_claim, ev_ovr, ev_data_wr, ev_stat_wr, ev_own_wr;

  assign restart    = base_wr || !rx_enable;
  assign ev_fetch   = (state_q == ST_FETCH) && !restart;
  assign ev_claim   = (state_q == ST_CHECK) && !restart && !mem_rdata[0];
  assign ev_ovr     = (state_q == ST_CHECK) && !restart &&  mem_rdata[0];
  assign ev_data_wr = (state_q == ST_WDATA) && !restart;
  assign ev_stat_wr = (state_q == ST_STAT)  && !restart;
  assign ev_own_wr  = (state_q == ST_OWN)   && !restart;

  assign s_ready = !restart && ((state_q == ST_RECV) || (state_q == ST_DROP) ||
                                ((state_q == ST_IDLE) && !s_sof));
  assign take    = s_valid && s_ready;
  assign ovr_flag = ovr_q;

  // Word address of the most recently filled byte.
  function automatic logic [ADDR_W-1:0] fill_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [OFF_W-1:0]  off);
    logic [OFF_W-1:0] last;
    last = off - OFF_W'(1);
    return b + ADDR_W'({last[OFF_W-1:2], 2'b00});
  endfunction

  rxr_ring_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_STEP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_load(base_wr),
    .base_val (base_data),
    .restart  (!rx_enable),
    .advance  (ev_own_wr),
    .ring_end (ring_end_q),
    .ptr_q    (ptr)
  );

  rxr_packer u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take && (state_q == ST_RECV)),
    .byte_in(s_data),
    .flush  (ev_data_wr || restart),
    .word_q (pk_word),
    .be_q   (pk_be),
    .lane_q (pk_lane)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    if (ev_fetch) begin
      mem_req = 1'b1;
    end else if (ev_data_wr) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = fill_addr(buf_q, off_q);
      mem_wdata = pk_word;
      mem_be    = pk_be;
    end else if (ev_stat_wr) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = ptr + ADDR_W'(4);
      mem_wdata = rxr_status_word(first_q, good_q, len_q, bc_q, am_q, tm_q);
    end else if (ev_own_wr) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_wdata = rxr_owned_word(32'(buf_q), ring_end_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_q <= 1'b0;
    else if (base_wr) ovr_q <= 1'b0;
    else if (ev_ovr) ovr_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      buf_q      <= '0;
      ring_end_q <= 1'b0;
      first_q    <= 1'b0;
      done_q     <= 1'b0;
      good_q     <= 1'b0;
      len_q      <= '0;
      off_q      <= '0;
      bc_q       <= 1'b0;
      am_q       <= '0;
      tm_q       <= 1'b0;
    end else if (restart) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (s_valid && s_sof) begin
          state_q <= ST_FETCH;
          first_q <= 1'b1;
          done_q  <= 1'b0;
          good_q  <= 1'b0;
          len_q   <= '0;
        end
        ST_FETCH: state_q <= ST_CHECK;
        ST_CHECK: if (mem_rdata[0]) begin
          state_q <= ST_DROP;
        end else begin
          buf_q      <= ADDR_W'(rxr_buf_addr(mem_rdata));
          ring_end_q <= mem_rdata[1];
          off_q      <= '0;
          state_q    <= ST_RECV;
        end
        ST_RECV: if (take) begin
          off_q <= off_q + OFF_W'(1);
          len_q <= len_q + LEN_W'(1);
          if (s_eof) begin
            done_q <= 1'b1;
            good_q <= !s_err;
            bc_q   <= s_bcast;
            am_q   <= s_amatch;
            tm_q   <= s_tmatch;
          end
          if (s_eof || pk_lane == 2'd3) state_q <= ST_WDATA;
        end
        ST_WDATA: state_q <= (done_q || off_q == OFF_W'(BUF_BYTES)) ? ST_STAT : ST_RECV;
        ST_STAT:  state_q <= ST_OWN;
        ST_OWN: begin
          first_q <= 1'b0;
          state_q <= done_q ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (take && s_eof) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_dma_chk.sv
module rxr_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              base_wr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic              ovr_flag,
  input logic              ev_stat_wr,
  input logic              ev_own_wr
);
  AST_FETCH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[2:0] == 3'd0)); // R1
  AST_STATUS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> (mem_we && mem_addr[2:0] == 3'd4)); // R1
  AST_OWN_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> $past(ev_stat_wr)); // R2
  AST_OWN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> (mem_wdata[0] && mem_be == 4'hF && mem_addr[2:0] == 3'd0)); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr_flag) && !$past(base_wr)) |-> ovr_flag); // R7
  AST_BASE_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !ovr_flag); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !mem_req); // R10
endmodule

bind rxr_dma_writer rxr_dma_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rxr_dma_writer_tb.sv
module rxr_dma_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING_BASE = 32'h40;
  localparam logic [31:0] BUF_BASE  = 32'h400;
  localparam int NDESC = 4;
  localparam int MEM_WORDS = 512;
  // Stimulus table: {length[18:7], {bcast,amatch[3:0],tmatch}[6:1], err[0]}
  localparam logic [18:0] VEC [6] = '{
    {12'd60,  6'b100000, 1'b0},
    {12'd128, 6'b000000, 1'b0},
    {12'd129, 6'b000010, 1'b0},
    {12'd300, 6'b000001, 1'b0},
    {12'd1,   6'b010000, 1'b0},
    {12'd256, 6'b101000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_enable = 1'b0, base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_err = 1'b0;
  logic s_bcast = 1'b0, s_tmatch = 1'b0;
  logic [3:0] s_amatch = '0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_req, mem_we, ovr_flag;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [31:0] mem [0:MEM_WORDS-1];
  logic sw_en = 1'b0;
  logic [31:0] sw_addr = '0, sw_data = '0;
  logic took = 1'b0;
  int n_checks = 0, n_fail = 0, off_req = 0, exp_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_dma_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_wr(base_wr), .base_data(base_data),
    .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_err(s_err),
    .s_bcast(s_bcast), .s_amatch(s_amatch), .s_tmatch(s_tmatch), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .ovr_flag(ovr_flag)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[10:2]];
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[10:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end else if (sw_en) begin
      mem[sw_addr[10:2]] <= sw_data;
    end
    took <= s_valid && s_ready;
    if (rst_n && !rx_enable && mem_req) off_req <= off_req + 1;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); sw_en = 1'b1; sw_addr = a; sw_data = d;
    @(negedge clk); sw_en = 1'b0;
  endtask

  function automatic logic [31:0] desc_addr(input int idx); return RING_BASE + 32'(8*idx); endfunction
  function automatic logic [31:0] buf_addr(input int idx); return BUF_BASE + 32'(128*idx); endfunction

  function automatic logic [31:0] exp_status(input bit first, input bit last, input int len, input logic [5:0] fl);
    logic [31:0] s;
    s = first ? 32'h4000 : 32'h0;
    if (last) s = s | 32'h8000 | 32'(len & 12'hFFF) | ({31'b0, fl[5]} << 31) |
                  ({28'b0, fl[4:1]} << 23) | ({31'b0, fl[0]} << 22);
    return s;
  endfunction

  task automatic send_frame(input int len, input logic [7:0] seed, input logic [5:0] fl, input bit err);
    @(negedge clk);
    for (int j = 0; j < len; j++) begin
      s_valid = 1'b1; s_data = seed + 8'(j);
      s_sof = (j == 0); s_eof = (j == len - 1); s_err = err && (j == len - 1);
      {s_bcast, s_amatch, s_tmatch} = (j == len - 1) ? fl : 6'b0;
      do @(negedge clk); while (!took);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_err = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_desc(input int idx, input logic [31:0] st, input logic [7:0] seed,
                            input int start, input int nb, input string tag);
    logic [31:0] w0, w1, a;
    int bad;
    w0 = mem[desc_addr(idx) >> 2];
    w1 = mem[(desc_addr(idx) + 4) >> 2];
    check(w0 == (buf_addr(idx) | ((idx == NDESC-1) ? 32'h2 : 32'h0) | 32'h1),
          {tag, " own/addr word"}, w0, buf_addr(idx) | ((idx == NDESC-1) ? 32'h2 : 32'h0) | 32'h1);
    check(w1 == st, {tag, " status"}, w1, st);
    bad = 0;
    for (int b = 0; b < nb; b++) begin
      a = buf_addr(idx) + 32'(b);
      if (mem[a >> 2][a[1:0]*8 +: 8] != seed + 8'(start + b)) bad++;
    end
    check(bad == 0, {tag, " data bytes"}, 32'(bad), 32'h0);
    sw_write(desc_addr(idx), w0 & ~32'h1);
  endtask

  task automatic check_frame(input int len, input logic [7:0] seed, input logic [5:0] fl,
                             input bit err, input string tag);
    int n, nb;
    n = (len + 127) / 128;
    for (int k = 0; k < n; k++) begin
      nb = (len - 128*k > 128) ? 128 : len - 128*k;
      check_desc((exp_idx + k) % NDESC, exp_status(k == 0, !err && k == n-1, len, fl),
                 seed, 128*k, nb, tag);
    end
    exp_idx = (exp_idx + n) % NDESC;
  endtask

  initial begin
    logic [31:0] w0s, w1s;
    int acc;
    repeat (3) @(negedge clk);
    check(!s_ready && !mem_req && !ovr_flag, "R11 reset outputs",
          {29'b0, s_ready, mem_req, ovr_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_ready && !mem_req && !ovr_flag, "R11 after release",
          {29'b0, s_ready, mem_req, ovr_flag}, 32'h0);
    for (int i = 0; i < NDESC; i++) begin
      sw_write(desc_addr(i), buf_addr(i) | ((i == NDESC-1) ? 32'h2 : 32'h0));
      sw_write(desc_addr(i) + 4, 32'h0);
    end
    @(negedge clk); base_wr = 1'b1; base_data = RING_BASE;
    @(negedge clk); base_wr = 1'b0; rx_enable = 1'b1;

    // Table walk: R1 R3 R4 R5 R6 (wrap through ring end with four descriptors)
    for (int v = 0; v < 6; v++) begin
      send_frame(int'(VEC[v][18:7]), 8'(16*v + 3), VEC[v][6:1], VEC[v][0]);
      check_frame(int'(VEC[v][18:7]), 8'(16*v + 3), VEC[v][6:1], VEC[v][0], "R1/R3/R4/R5/R6 table");
    end

    // R8: errored frame over two buffers, then a good frame resumes after them
    send_frame(200, 8'h77, 6'b111111, 1'b1);
    check_frame(200, 8'h77, 6'b111111, 1'b1, "R8 errored frame");
    send_frame(10, 8'h21, 6'b000001, 1'b0);
    check_frame(10, 8'h21, 6'b000001, 1'b0, "R8 resume");

    // R7: overrun before first byte; same descriptor retried
    w0s = mem[desc_addr(exp_idx) >> 2]; w1s = mem[(desc_addr(exp_idx) + 4) >> 2];
    sw_write(desc_addr(exp_idx), w0s | 32'h1);
    send_frame(50, 8'h90, 6'b100000, 1'b0);
    check(ovr_flag == 1'b1, "R7 overrun flag", {31'b0, ovr_flag}, 32'h1);
    check(mem[(desc_addr(exp_idx) + 4) >> 2] == w1s, "R7 owned status untouched",
          mem[(desc_addr(exp_idx) + 4) >> 2], w1s);
    sw_write(desc_addr(exp_idx), w0s);
    send_frame(20, 8'h05, 6'b000100, 1'b0);
    check_frame(20, 8'h05, 6'b000100, 1'b0, "R7 retry same descriptor");

    // R7: overrun in mid-frame (second descriptor owned)
    w0s = mem[desc_addr((exp_idx + 1) % NDESC) >> 2];
    w1s = mem[(desc_addr((exp_idx + 1) % NDESC) + 4) >> 2];
    sw_write(desc_addr((exp_idx + 1) % NDESC), w0s | 32'h1);
    send_frame(200, 8'hC0, 6'b100000, 1'b0);
    check_desc(exp_idx, 32'h4000, 8'hC0, 0, 128, "R7 partial first buffer");
    exp_idx = (exp_idx + 1) % NDESC;
    check(mem[(desc_addr(exp_idx) + 4) >> 2] == w1s, "R7 mid-frame owned untouched",
          mem[(desc_addr(exp_idx) + 4) >> 2], w1s);
    check(ovr_flag == 1'b1, "R7 overrun sticky", {31'b0, ovr_flag}, 32'h1);
    sw_write(desc_addr(exp_idx), w0s);
    send_frame(8, 8'h33, 6'b000000, 1'b0);
    check_frame(8, 8'h33, 6'b000000, 1'b0, "R7 retry after mid-frame drop");

    // R9: base write restarts ring and clears overrun
    send_frame(5, 8'h44, 6'b000000, 1'b0);
    check_frame(5, 8'h44, 6'b000000, 1'b0, "R9 pre-restart frame");
    @(negedge clk); base_wr = 1'b1; base_data = RING_BASE;
    @(negedge clk); base_wr = 1'b0;
    check(ovr_flag == 1'b0, "R9 overrun cleared", {31'b0, ovr_flag}, 32'h0);
    exp_idx = 0;
    send_frame(12, 8'h55, 6'b000010, 1'b0);
    check_frame(12, 8'h55, 6'b000010, 1'b0, "R9 restart at base");

    // R10: disabled reception
    rx_enable = 1'b0;
    acc = 0;
    s_valid = 1'b1; s_sof = 1'b1; s_eof = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (took) acc++;
    end
    s_valid = 1'b0; s_sof = 1'b0;
    check(acc == 0, "R10 no bytes taken while disabled", 32'(acc), 32'h0);
    check(off_req == 0, "R10 no memory access while disabled", 32'(off_req), 32'h0);
    @(negedge clk); rx_enable = 1'b1;
    exp_idx = 0;
    send_frame(30, 8'h66, 6'b001000, 1'b0);
    check_frame(30, 8'h66, 6'b001000, 1'b0, "R10 restart at base after enable");

    finish_run();
  end
endmodule